// File: doc/BRIEF.md
# Programmable Two-Phase Interframe Gap Timer

This block decides when a half-duplex Ethernet transmitter may start a frame that does not directly follow one of its own. Once the line goes quiet (no carrier and no transmission in progress) it counts nibble-time strobes until a programmable gap has passed. Only then does it raise a transmit-permitted flag.

The gap has two phases. During the first phase, the carrier window, any carrier activity throws the timer back to waiting for a quiet line. Once the window has passed, carrier is ignored and the count runs on to the end of the gap. Both lengths come from one 32-bit configuration word:
- the total gap is `5 + GAP_SET` nibble times;
- the window is `2 + WIN_SET` nibble times and forms the front part of the gap.

The reset word gives a 64-bit window inside a 96-bit gap, so the window is about two thirds of the gap, as recommended. The gap should never be set shorter than 96 bit times.

A waiting transmit request is granted as soon as the gap has elapsed.

Top module: `ifg_gap_timer`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `cfg_rd_data` reads 0x0000_0E13 and both `tx_ok` and `tx_grant` are 0.
- R2: The configuration word keeps GAP_SET in bits 6..0 and WIN_SET in bits 14..8. Bits 31..15 and bit 7 always read 0, and writing ones to them changes nothing. A full-word write is visible on `cfg_rd_data` one cycle after the write cycle.
- R3: After the line becomes quiet, `tx_ok` rises one clock after the clock that samples the (5 + GAP_SET)-th `nib_tick` strobe, and not before.
- R4: Carrier sampled while fewer than (2 + WIN_SET) strobes have been counted in the current gap discards the count. A new full gap starts once carrier drops.
- R5: Carrier sampled after (2 + WIN_SET) strobes have been counted has no effect: the gap still completes after the same total number of strobes.
- R6: Once raised, `tx_ok` stays 1 until `tx_active` or `crs` is sampled high, which clears it on the next cycle.
- R7: `tx_grant` is 1 exactly in the cycles that follow a clock edge at which `tx_req` was 1 and the timer was, or became, permitted.
- R8: A configuration write made while a gap is being timed leaves that gap unchanged and applies from the next gap.
- R9: `tx_active` sampled high during a gap, in either phase, discards the count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr_en | input | 1 | Full-word configuration write strobe |
| cfg_wr_data | input | 32 | Configuration write data |
| cfg_rd_data | output | 32 | Configuration read data |
| nib_tick | input | 1 | One-cycle strobe per nibble time |
| crs | input | 1 | Carrier sense from the line |
| tx_active | input | 1 | Own transmission in progress |
| tx_req | input | 1 | Frame waiting to be sent |
| tx_ok | output | 1 | Gap elapsed, transmission permitted |
| tx_grant | output | 1 | Request granted (registered) |

## Verification
Every result is registered:
- `tx_ok` changes one clock after the edge that samples the completing strobe, or the carrier or transmit-activity input that clears it.
- `tx_grant` follows `tx_req` with the same single-cycle delay.
- `cfg_rd_data` shows a write one cycle after its strobe.

The bench drives inputs and samples outputs on falling edges, so each sample falls after exactly one rising edge has applied the stimulus. A behavioural model advances on the same rising edge and is compared on every cycle. The directed checks count whole strobes up to one short of each boundary and then up to the boundary itself: the window edge at 15 versus 16 strobes, and the gap edge at 23 versus 24 strobes or at the reprogrammed length.

// File: rtl/ifg_pkg.sv
package ifg_pkg;
  typedef enum logic [1:0] {
    ST_WAIT  = 2'd0,
    ST_COUNT = 2'd1,
    ST_OPEN  = 2'd2
  } gap_state_t;

  localparam int unsigned WIN_OFFSET = 2;
  localparam int unsigned GAP_OFFSET = 5;
  localparam int unsigned WIN_LSB    = 8;
  localparam logic [31:0] CFG_RESET  = 32'h0000_0E13;
endpackage

// File: rtl/ifg_cfg_reg.sv
module ifg_cfg_reg #(
  parameter int unsigned FIELD_W = 7
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en,
  input  logic [31:0]        wr_data,
  output logic [31:0]        rd_data,
  output logic [FIELD_W-1:0] win_set,
  output logic [FIELD_W-1:0] gap_set
);
  import ifg_pkg::*;

  always_ff @(posedge clk) begin
    if (rst) begin
      win_set <= CFG_RESET[WIN_LSB +: FIELD_W];
      gap_set <= CFG_RESET[0 +: FIELD_W];
    end else if (wr_en) begin
      win_set <= wr_data[WIN_LSB +: FIELD_W];
      gap_set <= wr_data[0 +: FIELD_W];
    end
  end

  always_comb begin
    rd_data = '0;
    rd_data[WIN_LSB +: FIELD_W] = win_set;
    rd_data[0 +: FIELD_W]       = gap_set;
  end

  logic unused_rsvd;
  assign unused_rsvd = ^{wr_data[31:WIN_LSB+FIELD_W], wr_data[WIN_LSB-1:FIELD_W]};

  // R2
  wr_visible_chk: assert property (@(posedge clk) disable iff (rst)
    $past(wr_en) && !$past(rst) |-> gap_set == $past(wr_data[0 +: FIELD_W]));
endmodule

// File: rtl/ifg_tick_counter.sv
module ifg_tick_counter #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear,
  input  logic             step,
  output logic [CNT_W-1:0] count
);
  always_ff @(posedge clk) begin
    if (rst || clear) count <= '0;
    else if (step)    count <= count + 1'b1;
  end
endmodule

// File: rtl/ifg_gap_timer.sv
module ifg_gap_timer #(
  parameter int unsigned FIELD_W = 7
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        cfg_wr_en,
  input  logic [31:0] cfg_wr_data,
  output logic [31:0] cfg_rd_data,
  input  logic        nib_tick,
  input  logic        crs,
  input  logic        tx_active,
  input  logic        tx_req,
  output logic        tx_ok,
  output logic        tx_grant
);
  import ifg_pkg::*;

  localparam int unsigned CNT_W = FIELD_W + 1;

  logic [FIELD_W-1:0] win_set, gap_set;
  logic [CNT_W-1:0]   win_len, gap_len, count;
  gap_state_t         state, state_nx;
  logic               cnt_clear, cnt_step, load;

  ifg_cfg_reg #(.FIELD_W(FIELD_W)) u_cfg (
    .clk(clk), .rst(rst), .wr_en(cfg_wr_en), .wr_data(cfg_wr_data),
    .rd_data(cfg_rd_data), .win_set(win_set), .gap_set(gap_set)
  );

  ifg_tick_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .clear(cnt_clear), .step(cnt_step), .count(count)
  );

  always_comb begin
    state_nx = state;
    load     = 1'b0;
    unique case (state)
      ST_WAIT: begin
        if (!crs && !tx_active) begin
          state_nx = ST_COUNT;
          load     = 1'b1;
        end
      end
      ST_COUNT: begin
        if (tx_active || (crs && count < win_len))
          state_nx = ST_WAIT;
        else if (nib_tick && (count + 1'b1) >= gap_len)
          state_nx = ST_OPEN;
      end
      ST_OPEN: begin
        if (tx_active || crs) state_nx = ST_WAIT;
      end
      default: state_nx = ST_WAIT;
    endcase
  end

  assign cnt_clear = (state_nx != ST_COUNT);
  assign cnt_step  = (state == ST_COUNT) && (state_nx == ST_COUNT) && nib_tick;

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_WAIT;
      win_len  <= '0;
      gap_len  <= '0;
      tx_ok    <= 1'b0;
      tx_grant <= 1'b0;
    end else begin
      state    <= state_nx;
      tx_ok    <= (state_nx == ST_OPEN);
      tx_grant <= (state_nx == ST_OPEN) && tx_req;
      if (load) begin
        win_len <= CNT_W'(win_set) + CNT_W'(WIN_OFFSET);
        gap_len <= CNT_W'(gap_set) + CNT_W'(GAP_OFFSET);
      end
    end
  end

  // R1
  reset_state_chk: assert property (@(posedge clk)
    $past(rst) |-> !tx_ok && !tx_grant && cfg_rd_data == CFG_RESET);
  // R3
  open_on_tick_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(tx_ok) |-> $past(nib_tick));
  // R6
  ok_hold_chk: assert property (@(posedge clk) disable iff (rst)
    tx_ok && !crs && !tx_active |=> tx_ok);
  // R7
  grant_needs_ok_chk: assert property (@(posedge clk) disable iff (rst)
    tx_grant |-> tx_ok);
  // R8
  len_frozen_chk: assert property (@(posedge clk) disable iff (rst)
    state == ST_COUNT && $past(state == ST_COUNT) |-> $stable(gap_len) && $stable(win_len));
  // R9
  active_clears_chk: assert property (@(posedge clk) disable iff (rst)
    tx_active |=> !tx_ok);
endmodule

// File: tb/ifg_gap_timer_test.sv
module ifg_gap_timer_test;
  logic clk = 0, rst = 1;
  logic cfg_wr_en = 0;
  logic [31:0] cfg_wr_data = '0;
  logic [31:0] cfg_rd_data;
  logic nib_tick = 0, crs = 0, tx_active = 0, tx_req = 0;
  logic tx_ok, tx_grant;

  int checks = 0, errors = 0, cycles = 0;
  bit done = 0;

  ifg_gap_timer uut (
    .clk(clk), .rst(rst), .cfg_wr_en(cfg_wr_en), .cfg_wr_data(cfg_wr_data),
    .cfg_rd_data(cfg_rd_data), .nib_tick(nib_tick), .crs(crs),
    .tx_active(tx_active), .tx_req(tx_req), .tx_ok(tx_ok), .tx_grant(tx_grant)
  );

  always #4 clk = ~clk;

  // behavioural reference: phase 0 waiting, 1 counting, 2 open
  int m_phase, m_seen, m_win, m_gap;
  logic [31:0] m_cfg;
  bit m_ok, m_gr;

  always @(posedge clk) begin
    if (rst) begin
      m_cfg = 32'h0000_0E13; m_phase = 0; m_seen = 0; m_ok = 0; m_gr = 0;
    end else begin
      if (m_phase == 0) begin
        if (!crs && !tx_active) begin
          m_phase = 1; m_seen = 0;
          m_win = 2 + int'((m_cfg >> 8) & 32'h7F);
          m_gap = 5 + int'(m_cfg & 32'h7F);
        end
      end else if (m_phase == 1) begin
        if (tx_active || (crs && m_seen < m_win)) m_phase = 0;
        else if (nib_tick) begin
          m_seen++;
          if (m_seen >= m_gap) m_phase = 2;
        end
      end else if (tx_active || crs) m_phase = 0;
      m_ok = (m_phase == 2);
      m_gr = m_ok && tx_req;
      if (cfg_wr_en) m_cfg = cfg_wr_data & 32'h0000_7F7F;
    end
  end

  always @(negedge clk) begin
    cycles++;
    if (!done) begin
      checks++;
      if (tx_ok !== m_ok || tx_grant !== m_gr || cfg_rd_data !== m_cfg) begin
        errors++;
        $display("FAIL R3/R7 model cycle %0d: ok=%b grant=%b cfg=%h expected ok=%b grant=%b cfg=%h",
                 cycles, tx_ok, tx_grant, cfg_rd_data, m_ok, m_gr, m_cfg);
      end
      if (cycles > 50000) begin
        errors++;
        $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic ticks(input int n);
    repeat (n) begin
      @(negedge clk); nib_tick = 1;
      @(negedge clk); nib_tick = 0;
    end
  endtask

  task automatic wr(input logic [31:0] d);
    @(negedge clk); cfg_wr_en = 1; cfg_wr_data = d;
    @(negedge clk); cfg_wr_en = 0;
  endtask

  task automatic pulse_active();
    @(negedge clk); tx_active = 1;
    @(negedge clk); tx_active = 0;
  endtask

  initial begin
    idle(3);
    chk("R1 cfg reset", cfg_rd_data, 32'h0000_0E13);
    chk("R1 tx_ok reset", {31'd0, tx_ok}, 32'd0);
    chk("R1 grant reset", {31'd0, tx_grant}, 32'd0);
    rst = 0;
    ticks(23); chk("R3 one short of gap", {31'd0, tx_ok}, 32'd0);
    ticks(1);  chk("R3 gap reached", {31'd0, tx_ok}, 32'd1);
    idle(10);  chk("R6 held while quiet", {31'd0, tx_ok}, 32'd1);
    tx_req = 1; idle(1);
    chk("R7 grant", {31'd0, tx_grant}, 32'd1);
    tx_req = 0; idle(1);
    chk("R7 grant drops", {31'd0, tx_grant}, 32'd0);
    pulse_active();
    chk("R6 cleared by transmit", {31'd0, tx_ok}, 32'd0);
    // window boundary: carrier at 15 counted strobes restarts
    ticks(15); crs = 1; idle(1); crs = 0;
    ticks(23); chk("R4 restart, one short", {31'd0, tx_ok}, 32'd0);
    ticks(1);  chk("R4 restart, full gap", {31'd0, tx_ok}, 32'd1);
    crs = 1; idle(1); crs = 0;
    chk("R6 cleared by carrier", {31'd0, tx_ok}, 32'd0);
    // carrier at 16 counted strobes is ignored
    ticks(16); crs = 1; idle(2); crs = 0;
    ticks(7);  chk("R5 carrier ignored, one short", {31'd0, tx_ok}, 32'd0);
    ticks(1);  chk("R5 carrier ignored, gap kept", {31'd0, tx_ok}, 32'd1);
    // mid-gap reconfiguration
    pulse_active();
    ticks(3);
    wr(32'h0000_0E00);
    chk("R8 readback", cfg_rd_data, 32'h0000_0E00);
    ticks(2);  chk("R8 old gap still used", {31'd0, tx_ok}, 32'd0);
    ticks(19); chk("R8 old gap completes", {31'd0, tx_ok}, 32'd1);
    pulse_active();
    ticks(4);  chk("R8 new gap, one short", {31'd0, tx_ok}, 32'd0);
    ticks(1);  chk("R8 new gap reached", {31'd0, tx_ok}, 32'd1);
    // reserved bits
    wr(32'hFFFF_FFFF);
    chk("R2 reserved read zero", cfg_rd_data, 32'h0000_7F7F);
    wr(32'hFFFF_8385);
    chk("R2 reserved writes ignored", cfg_rd_data, 32'h0000_0305);
    // transmit activity after window restarts (window 5, gap 10)
    pulse_active();
    ticks(6); pulse_active();
    ticks(9); chk("R9 restart, one short", {31'd0, tx_ok}, 32'd0);
    ticks(1); chk("R9 restart, full gap", {31'd0, tx_ok}, 32'd1);
    idle(2);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule